// File: doc/BRIEF.md
# Serial Bitstream Input Receiver

This block takes a compressed audio stream from an external source that supplies a serial clock, a serial data line and a bit-enable line. All three inputs are brought into the system clock domain through two-flop synchronisers. Edges of the serial clock are then detected in that domain. The serial clock must run at no more than a quarter of the system clock rate.

On the selected edge, a data bit is taken only while the enable line is high. Bits are packed most significant first into bytes. Each completed byte goes into a 16-entry buffer, which a downstream consumer drains through a valid/ready handshake. The block drives a data-request line back to the source and holds it active while the buffer is less than half full. The line's polarity and its registered or direct drive are set through a small write/read register port.

Top module: `bitstream_rx`

## Requirements
- R1: The edge-select register (address 0) has reset value 0x00. With its bit 2 clear, data is sampled on the rising edge of `ser_clk`. Writing 0x04 moves sampling to the falling edge.
- R2: A bit is taken only when `ser_en` is high at the sampling edge. An edge with `ser_en` low leaves the partial byte unchanged, and no byte appears at the output.
- R3: Bits are assembled most significant first. After eight accepted bits, the byte is offered on `out_data`, with `out_valid` high.
- R4: A partial byte is kept across any stretch of edges with `ser_en` low, and it completes when enabled bits resume. A reset discards a partial byte.
- R5: The buffer holds 16 bytes and returns them in arrival order. A byte is removed on a cycle where `out_valid` and `out_ready` are both high. `fifo_empty` is high exactly when no byte is held.
- R6: A byte completed while 16 bytes are held is dropped. `overflow` then goes high and stays high until reset.
- R7: The request is active while fewer than 8 bytes are held, and inactive when 8 or more are held.
- R8: The request-polarity register (address 1) resets to 0x01. Bit 0 set drives `data_req` high when active. Bit 0 clear drives it low when active.
- R9: The request-mode register (address 2) resets to 0x00. With bit 2 clear, `data_req` follows the buffer level one system clock late (registered). With bit 2 set, it follows in the same cycle (direct).
- R10: A write with `cfg_we` high stores `cfg_wdata` in the addressed register. `cfg_rdata` returns that register's full 8-bit value, and address 3 reads 0x00. An active-low `rst_n` restores all reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial bit clock from the source |
| ser_dat | input | 1 | Serial data |
| ser_en | input | 1 | Bit-enable; bits count only while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| data_req | output | 1 | Data request to the source |
| out_data | output | 8 | Oldest buffered byte |
| out_valid | output | 1 | A byte is available |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| fifo_empty | output | 1 | Buffer holds no byte |
| overflow | output | 1 | Sticky: a byte was dropped on a full buffer |

## Verification
Bytes are sent with different data on the rising and the falling half of each serial clock period. The byte that comes out therefore shows which edge was sampled. Disabled bits carrying ones are inserted in the middle of a byte, which separates ignoring them from shifting them in, or from restarting the byte. The buffer is filled across the 7/8 threshold to check when the request changes. It is then popped once in each drive mode to separate registered from direct timing, and it is finally overrun with a seventeenth byte to show which byte is lost.

// File: rtl/bsrx_pkg.sv
package bsrx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EDGE    = 2'd0,
    REG_REQPOL  = 2'd1,
    REG_REQMODE = 2'd2,
    REG_NONE    = 2'd3
  } reg_addr_e;

  localparam int unsigned EDGE_FALL_BIT = 2;
  localparam int unsigned REQ_HIGH_BIT  = 0;
  localparam int unsigned REQ_DIRECT_BIT = 2;

  localparam logic [BYTE_W-1:0] EDGE_RST    = 8'h00;
  localparam logic [BYTE_W-1:0] REQPOL_RST  = 8'h01;
  localparam logic [BYTE_W-1:0] REQMODE_RST = 8'h00;
endpackage

// File: rtl/bsrx_sync.sv
module bsrx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= (s == 0) ? async_i : stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bsrx_shift.sv
module bsrx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sdat_s,
  input  logic         sen_s,
  input  logic         fall_sel,
  output logic         push,
  output logic [W-1:0] push_data
);
  localparam int unsigned CW = $clog2(W);

  logic          prev_q;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sample;
  logic          take;

  assign sample = fall_sel ? (prev_q & ~sclk_s) : (~prev_q & sclk_s);
  assign take   = sample & sen_s;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    push  = 1'b0;
    if (take) begin
      sh_d = {sh_q[W-2:0], sdat_s};
      if (cnt_q == CW'(W-1)) begin
        push  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign push_data = {sh_q[W-2:0], sdat_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sclk_s;
      if (take) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
      end
    end
  end

  AST_NO_SHIFT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cnt_q)) else $error("bit count moved without an enabled edge"); // R2
endmodule

// File: rtl/bsrx_fifo.sv
module bsrx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop_ready,
  output logic [W-1:0]               head,
  output logic                       valid,
  output logic                       empty,
  output logic                       ovf,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, pop, wr_en;

  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign valid = ~empty;
  assign pop   = valid & pop_ready;
  assign wr_en = push & ~full;
  assign head  = mem_q[rd_q];
  assign level = cnt_q;
  assign ovf   = ovf_q;

  always_comb begin
    wr_d  = wr_en ? wr_q + 1'b1 : wr_q;
    rd_d  = pop   ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q;
    if (wr_en && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && pop) cnt_d = cnt_q - 1'b1;
    ovf_d = ovf_q | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH)) else $error("level above depth"); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q) else $error("overflow flag cleared"); // R6
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)) && ovf_q) else $error("push on full not dropped"); // R6
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> cnt_q == $past(cnt_q) - 1'b1) else $error("pop did not lower level"); // R5
endmodule

// File: rtl/bitstream_rx.sv
module bitstream_rx
  import bsrx_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned REQ_LEVEL   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  output logic              data_req,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              fifo_empty,
  output logic              overflow
);
  localparam int unsigned LW = $clog2(DEPTH) + 1;

  logic        rst_meta_q, rst_sync_n;
  logic [2:0]  ser_s;
  logic        push;
  logic [BYTE_W-1:0] push_data;
  logic [LW-1:0] level;
  logic [BYTE_W-1:0] edge_q, edge_d, pol_q, pol_d, mode_q, mode_d;
  logic        req_raw, req_q, req_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bsrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i ({ser_clk, ser_dat, ser_en}),
    .sync_o  (ser_s)
  );

  bsrx_shift #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sclk_s    (ser_s[2]),
    .sdat_s    (ser_s[1]),
    .sen_s     (ser_s[0]),
    .fall_sel  (edge_q[EDGE_FALL_BIT]),
    .push      (push),
    .push_data (push_data)
  );

  bsrx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_data (push_data),
    .pop_ready (out_ready),
    .head      (out_data),
    .valid     (out_valid),
    .empty     (fifo_empty),
    .ovf       (overflow),
    .level     (level)
  );

  always_comb begin
    edge_d = edge_q;
    pol_d  = pol_q;
    mode_d = mode_q;
    if (cfg_we) begin
      case (reg_addr_e'(cfg_addr))
        REG_EDGE:    edge_d = cfg_wdata;
        REG_REQPOL:  pol_d  = cfg_wdata;
        REG_REQMODE: mode_d = cfg_wdata;
        default:     ;
      endcase
    end
    case (reg_addr_e'(cfg_addr))
      REG_EDGE:    cfg_rdata = edge_q;
      REG_REQPOL:  cfg_rdata = pol_q;
      REG_REQMODE: cfg_rdata = mode_q;
      default:     cfg_rdata = '0;
    endcase
  end

  assign req_raw  = (level < LW'(REQ_LEVEL));
  assign req_sel  = mode_q[REQ_DIRECT_BIT] ? req_raw : req_q;
  assign data_req = pol_q[REQ_HIGH_BIT] ? req_sel : ~req_sel;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      edge_q <= EDGE_RST;
      pol_q  <= REQPOL_RST;
      mode_q <= REQMODE_RST;
      req_q  <= 1'b1;
    end else begin
      if (cfg_we) begin
        edge_q <= edge_d;
        pol_q  <= pol_d;
        mode_q <= mode_d;
      end
      req_q <= req_raw;
    end
  end

  AST_REQ_FULL_DIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q[REQ_DIRECT_BIT] && pol_q[REQ_HIGH_BIT] && level >= LW'(REQ_LEVEL)) |-> !data_req)
    else $error("request active above threshold"); // R7
endmodule

// File: tb/bitstream_rx_tb_top.sv
module bitstream_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SER   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       data_req;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       fifo_empty, overflow;

  int n_vec = 0;
  int n_err = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .data_req(data_req), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .fifo_empty(fifo_empty), .overflow(overflow)
  );

  // {falling-edge select, byte on rising halves, byte on falling halves}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h5A}, {1'b1, 8'h3C, 8'hC3}, {1'b1, 8'h00, 8'h81},
    {1'b0, 8'h80, 8'h7F}, {1'b0, 8'hFF, 8'h00}, {1'b1, 8'h12, 8'hED}
  };

  function automatic logic [7:0] val(input int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_bit(input logic d_r, input logic d_f, input logic e);
    ser_dat = d_r; ser_en = e;
    tick(HALF_SER);
    ser_clk = 1'b1;
    tick(HALF_SER);
    ser_dat = d_f;
    tick(HALF_SER);
    ser_clk = 1'b0;
    tick(HALF_SER);
  endtask

  task automatic send_split(input logic [7:0] r, input logic [7:0] f);
    for (int b = 7; b >= 0; b--) send_bit(r[b], f[b], 1'b1);
    ser_en = 1'b0;
    tick(3);
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {24'd0, out_data}, {24'd0, exp});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_err++;
        $display("FAIL watchdog (all requirements) act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
      end
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(5);

    // reset state: R8 R9 R10 R5 R6 R7
    cfg_addr = 2'd0; tick(1);
    chk("R10 edge reg reset", {24'd0, cfg_rdata}, 32'h00);
    cfg_addr = 2'd1; tick(1);
    chk("R8 polarity reg reset", {24'd0, cfg_rdata}, 32'h01);
    cfg_addr = 2'd2; tick(1);
    chk("R9 mode reg reset", {24'd0, cfg_rdata}, 32'h00);
    chk("R5 empty at reset", {31'd0, fifo_empty}, 32'd1);
    chk("R5 no valid at reset", {31'd0, out_valid}, 32'd0);
    chk("R6 no overflow at reset", {31'd0, overflow}, 32'd0);
    chk("R7 request active at reset", {31'd0, data_req}, 32'd1);

    // vector table: edge select and MSB-first assembly, R1 R3
    for (int v = 0; v < 6; v++) begin
      cfg_write(2'd0, VEC[v][16] ? 8'h04 : 8'h00);
      send_split(VEC[v][15:8], VEC[v][7:0]);
      pop_check("R1 R3 edge/byte", VEC[v][16] ? VEC[v][7:0] : VEC[v][15:8]);
      tick(1);
      chk("R5 empty after pop", {31'd0, fifo_empty}, 32'd1);
    end
    cfg_write(2'd0, 8'h00);

    // disabled bits in the middle of a byte: R2 R4
    send_bit(1, 1, 1); send_bit(1, 1, 1); send_bit(0, 0, 1); send_bit(0, 0, 1);
    for (int k = 0; k < 3; k++) send_bit(1, 1, 0);
    send_bit(0, 0, 1); send_bit(0, 0, 1); send_bit(1, 1, 1);
    tick(6);
    chk("R2 no byte after 7 enabled bits", {31'd0, fifo_empty}, 32'd1);
    send_bit(1, 1, 1);
    ser_en = 1'b0;
    tick(3);
    pop_check("R2 R4 gap kept", 8'hC3);

    // request threshold and modes: R7 R9 R8
    for (int i = 0; i < 7; i++) send_split(val(i), val(i));
    tick(2);
    chk("R7 request active at 7", {31'd0, data_req}, 32'd1);
    send_split(val(7), val(7));
    tick(2);
    chk("R7 request inactive at 8", {31'd0, data_req}, 32'd0);
    cfg_write(2'd2, 8'h04);
    @(negedge clk);
    chk("R5 order head", {24'd0, out_data}, {24'd0, val(0)});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 direct follows same cycle", {31'd0, data_req}, 32'd1);
    send_split(val(8), val(8));
    tick(2);
    chk("R7 inactive again at 8", {31'd0, data_req}, 32'd0);
    cfg_write(2'd2, 8'h00);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 registered lags one cycle", {31'd0, data_req}, 32'd0);
    @(negedge clk);
    chk("R9 registered after lag", {31'd0, data_req}, 32'd1);
    cfg_write(2'd1, 8'h00);
    tick(1);
    chk("R8 active-low request", {31'd0, data_req}, 32'd0);
    cfg_write(2'd1, 8'h01);
    for (int i = 2; i < 9; i++) pop_check("R5 arrival order", val(i));
    tick(1);
    chk("R5 empty after drain", {31'd0, fifo_empty}, 32'd1);

    // overrun: R6
    for (int i = 0; i < 17; i++) send_split(val(20 + i), val(20 + i));
    tick(2);
    chk("R6 overflow set", {31'd0, overflow}, 32'd1);
    for (int i = 0; i < 16; i++) pop_check("R6 kept bytes", val(20 + i));
    tick(1);
    chk("R6 extra byte dropped", {31'd0, fifo_empty}, 32'd1);
    chk("R6 overflow sticky", {31'd0, overflow}, 32'd1);

    // register readback: R10
    cfg_write(2'd1, 8'h5B);
    cfg_addr = 2'd1; tick(1);
    chk("R10 readback", {24'd0, cfg_rdata}, 32'h5B);
    cfg_write(2'd3, 8'hFF);
    cfg_addr = 2'd3; tick(1);
    chk("R10 unused address", {24'd0, cfg_rdata}, 32'h00);

    // partial byte discarded on reset: R4 R10
    send_bit(1, 1, 1); send_bit(1, 1, 1); send_bit(1, 1, 1);
    @(negedge clk);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    chk("R6 overflow cleared by reset", {31'd0, overflow}, 32'd0);
    cfg_addr = 2'd1; tick(1);
    chk("R10 polarity restored", {24'd0, cfg_rdata}, 32'h01);
    send_split(8'h69, 8'h69);
    pop_check("R4 partial discarded", 8'h69);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule